// File: doc/BRIEF.md
# Double-Buffered Clock Register Window

This block places eight timekeeping registers at the eight highest byte addresses of a byte-wide memory bus. The bus is controlled by active-low chip select, output enable and write enable. Software reads and writes a visible copy of the time. A separate counter block keeps the live time, and this window is connected to it through a live-time input, a one-second tick and a load port. Any access below the window is passed on to a neighbouring RAM through its own chip select.

Two control bits freeze the visible copy. The read bit holds a snapshot so that software can read the registers without catching them in the middle of an update, while the counters keep running. The write bit lets software stage a new time, which is handed to the counters as one load pulse when the bit is cleared. A frequency-test bit in the day register replaces bit 0 of the seconds register with a 512 Hz level supplied by the counter block. Bits with no clock function are plain storage.

Top module: `rtc_window`

## Requirements
- R1: The window is the set of addresses whose bits above bit 2 are all 1. Inside it, the offset in address bits 2:0 selects a register: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. `ram_cs_n` is low only when `cs_n` is low and the address lies below the window.
- R2: `rdata_oe` is 1 exactly when `cs_n`=0, `oe_n`=0, `we_n`=1 and the address is in the window. `rdata` then carries the selected register and is 0 at all other times.
- R3: A write commits once per access, in the first clock cycle in which `cs_n` and `we_n` are both low, whichever of the two fell later. Data changes while both stay low are not stored.
- R4: While control bits 7 and 6 are both 0, each `tick_1s` cycle loads the clock bits of registers 1..7 from `live_time`, where register k sits at bits [8k-1:8k-8]. The clock bit masks are: seconds 0x7F, minutes 0x7F, hours 0x3F, day 0x07, date 0x3F, month 0x1F, year 0xFF.
- R5: Every bit of all eight registers can be written and read back. Bits outside the clock mask keep their written value across ticks.
- R6: Control bit 6 (read bit) set to 1 holds all visible registers through ticks. After both control bits return to 0, the next tick refreshes the registers from `live_time`, and no refresh happens before that tick.
- R7: Writing the control register with bit 7 changing from 1 to 0 raises `ld_stb` for exactly the following cycle. `ld_time` then carries the masked clock bits of registers 1..7, packed as in R4. No other write raises `ld_stb`.
- R8: A time-register write made while neither control bit is set produces no `ld_stb`. The written value reads back until the next tick, which overwrites its clock bits with live values.
- R9: With both control bits set, clearing only bit 7 still issues the load of R7, and the registers stay frozen through ticks until bit 6 is also cleared.
- R10: `osc_stop` equals bit 7 of the seconds register.
- R11: When day bit 6 is 1 and seconds bit 7 is 0, a read of the seconds register returns `hz512` in bit 0. Otherwise it returns the stored bit 0.
- R12: After reset all registers read 0, and `ld_stb` and `osc_stop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not driven |
| rdata_oe | output | 1 | Read data drive enable |
| ram_cs_n | output | 1 | Chip select for the RAM below the window |
| tick_1s | input | 1 | One-second tick from the counters |
| hz512 | input | 1 | 512 Hz square wave from the counters |
| live_time | input | 56 | Live counter values for registers 1..7 |
| ld_stb | output | 1 | One-cycle load pulse to the counters |
| ld_time | output | 56 | Time values to load, clock bits only |
| osc_stop | output | 1 | Oscillator stop request |

## Verification
The hardest case to reach from the ports is a frozen window that receives ticks while the control bits are released one at a time. Examples are the write bit cleared while the read bit stays set, and a release followed by reads before the first tick. The stimulus drives these sequences explicitly, with changing live values on every tick, and compares every register against a bench model after each step. Write-start detection is covered by holding the write strobe low across several edges while the data changes, with chip select falling both before and together with write enable.

// File: rtl/rtc_win_pkg.sv
package rtc_win_pkg;
   localparam int NREG     = 8;
   localparam int OFF_W    = $clog2(NREG);
   localparam int BYTE_W   = 8;
   localparam int TIME_W   = (NREG - 1) * BYTE_W;

   localparam int OFF_CTL  = 0;
   localparam int OFF_SEC  = 1;
   localparam int OFF_MIN  = 2;
   localparam int OFF_HOUR = 3;
   localparam int OFF_DAY  = 4;
   localparam int OFF_DATE = 5;
   localparam int OFF_MON  = 6;
   localparam int OFF_YEAR = 7;

   localparam int CTL_WBIT    = 7;
   localparam int CTL_RBIT    = 6;
   localparam int SEC_STOPBIT = 7;
   localparam int DAY_FTBIT   = 6;

   function automatic logic [BYTE_W-1:0] clk_mask(input int off);
      case (off)
         OFF_SEC:  clk_mask = 8'h7F;
         OFF_MIN:  clk_mask = 8'h7F;
         OFF_HOUR: clk_mask = 8'h3F;
         OFF_DAY:  clk_mask = 8'h07;
         OFF_DATE: clk_mask = 8'h3F;
         OFF_MON:  clk_mask = 8'h1F;
         OFF_YEAR: clk_mask = 8'hFF;
         default:  clk_mask = 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/rtc_win_decode.sv
module rtc_win_decode
   import rtc_win_pkg::*;
#(
   parameter int ADDR_W = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [OFF_W-1:0]  offset,
   output logic              wr_win,
   output logic [NREG-1:0]   wr_sel,
   output logic              rd_en,
   output logic              ram_cs_n
);
   logic wr_act;
   logic wr_act_q;
   logic wr_stb;
   logic in_win;

   generate
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("rtc_win_decode: ADDR_W must exceed the register offset width");
      end
   endgenerate

   assign wr_act = !cs_n && !we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_act_q <= 1'b0;
      else        wr_act_q <= wr_act;
   end

   assign wr_stb   = wr_act && !wr_act_q;
   assign in_win   = &addr[ADDR_W-1:OFF_W];
   assign offset   = addr[OFF_W-1:0];
   assign wr_win   = wr_stb && in_win;
   assign rd_en    = !cs_n && !oe_n && we_n && in_win;
   assign ram_cs_n = cs_n || in_win;

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_sel
         assign wr_sel[g] = wr_win && (offset == OFF_W'(g));
      end
   endgenerate
endmodule

// File: rtl/rtc_win_ctrl.sv
module rtc_win_ctrl
   import rtc_win_pkg::*;
#(
   parameter bit REFRESH_ON_CLEAR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctl,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              tick,
   output logic [BYTE_W-1:0] ctl_q,
   output logic              freeze,
   output logic              track,
   output logic              rfsh,
   output logic              ld_stb
);
   assign freeze = ctl_q[CTL_WBIT] || ctl_q[CTL_RBIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         ld_stb <= 1'b0;
      end else begin
         ld_stb <= wr_ctl && ctl_q[CTL_WBIT] && !wdata[CTL_WBIT];
         if (wr_ctl) ctl_q <= wdata;
      end
   end

   generate
      if (REFRESH_ON_CLEAR) begin : g_fast
         logic rel;
         logic rel_q1;
         logic rel_q2;
         assign rel = wr_ctl && freeze && !wdata[CTL_WBIT] && !wdata[CTL_RBIT];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rel_q1 <= 1'b0;
               rel_q2 <= 1'b0;
            end else begin
               rel_q1 <= rel;
               rel_q2 <= rel_q1;
            end
         end
         assign rfsh = rel_q2 && !freeze;
      end else begin : g_tick
         assign rfsh = 1'b0;
      end
   endgenerate

   assign track = (tick && !freeze) || rfsh;
endmodule

// File: rtl/rtc_win_hold.sv
module rtc_win_hold
   import rtc_win_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NREG-1:1]   wr_sel,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              track,
   input  logic [TIME_W-1:0] live,
   output logic [TIME_W-1:0] vis,
   output logic [TIME_W-1:0] vis_clk
);
   generate
      for (genvar g = 1; g < NREG; g++) begin : g_reg
         localparam logic [BYTE_W-1:0] MASK = clk_mask(g);
         localparam int LSB = (g - 1) * BYTE_W;
         logic [BYTE_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_sel[g])
               q <= wdata;
            else if (track)
               q <= (live[LSB +: BYTE_W] & MASK) | (q & ~MASK);
         end
         assign vis[LSB +: BYTE_W]     = q;
         assign vis_clk[LSB +: BYTE_W] = q & MASK;
      end
   endgenerate
endmodule

// File: rtl/rtc_win_rdmux.sv
module rtc_win_rdmux
   import rtc_win_pkg::*;
#(
   parameter bit FT_ENABLE = 1'b1
) (
   input  logic              rd_en,
   input  logic [OFF_W-1:0]  offset,
   input  logic [BYTE_W-1:0] ctl_q,
   input  logic [TIME_W-1:0] vis,
   input  logic              hz512,
   output logic [BYTE_W-1:0] rdata
);
   logic [BYTE_W-1:0] sel_b;
   logic [BYTE_W-1:0] out_b;

   always_comb begin
      sel_b = ctl_q;
      for (int k = 1; k < NREG; k++) begin
         if (offset == OFF_W'(k)) sel_b = vis[(k-1)*BYTE_W +: BYTE_W];
      end
   end

   generate
      if (FT_ENABLE) begin : g_ft
         logic ft_on;
         assign ft_on = vis[(OFF_DAY-1)*BYTE_W + DAY_FTBIT]
                     && !vis[(OFF_SEC-1)*BYTE_W + SEC_STOPBIT]
                     && (offset == OFF_W'(OFF_SEC));
         assign out_b = {sel_b[BYTE_W-1:1], ft_on ? hz512 : sel_b[0]};
      end else begin : g_noft
         logic unused_hz;
         assign unused_hz = hz512;
         assign out_b = sel_b;
      end
   endgenerate

   assign rdata = rd_en ? out_b : '0;
endmodule

// File: rtl/rtc_window.sv
module rtc_window
   import rtc_win_pkg::*;
#(
   parameter int ADDR_W           = 19,
   parameter bit FT_ENABLE        = 1'b1,
   parameter bit REFRESH_ON_CLEAR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              rdata_oe,
   output logic              ram_cs_n,
   input  logic              tick_1s,
   input  logic              hz512,
   input  logic [55:0]       live_time,
   output logic              ld_stb,
   output logic [55:0]       ld_time,
   output logic              osc_stop
);
   generate
      if (TIME_W != 56 || BYTE_W != 8) begin : g_bad_map
         $error("rtc_window: register map must be seven time bytes plus control");
      end
   endgenerate

   logic [OFF_W-1:0]  offset;
   logic              wr_win;
   logic [NREG-1:0]   wr_sel;
   logic              rd_en;
   logic [BYTE_W-1:0] ctl_q;
   logic              freeze;
   logic              track;
   logic              rfsh;
   logic [TIME_W-1:0] vis_q;
   logic [TIME_W-1:0] vis_clk;

   rtc_win_decode #(.ADDR_W(ADDR_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .offset(offset), .wr_win(wr_win), .wr_sel(wr_sel),
      .rd_en(rd_en), .ram_cs_n(ram_cs_n)
   );

   rtc_win_ctrl #(.REFRESH_ON_CLEAR(REFRESH_ON_CLEAR)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_ctl(wr_sel[OFF_CTL]), .wdata(wdata),
      .tick(tick_1s), .ctl_q(ctl_q), .freeze(freeze), .track(track),
      .rfsh(rfsh), .ld_stb(ld_stb)
   );

   rtc_win_hold u_hold (
      .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel[NREG-1:1]), .wdata(wdata),
      .track(track), .live(live_time), .vis(vis_q), .vis_clk(vis_clk)
   );

   rtc_win_rdmux #(.FT_ENABLE(FT_ENABLE)) u_rd (
      .rd_en(rd_en), .offset(offset), .ctl_q(ctl_q), .vis(vis_q),
      .hz512(hz512), .rdata(rdata)
   );

   assign rdata_oe = rd_en;
   assign ld_time  = vis_clk;
   assign osc_stop = vis_q[(OFF_SEC-1)*BYTE_W + SEC_STOPBIT];
endmodule

// File: rtl/rtc_win_chk.sv
module rtc_win_chk #(
   parameter int VW = 56
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_n,
   input logic          oe_n,
   input logic          we_n,
   input logic [7:0]    rdata,
   input logic          rdata_oe,
   input logic          ram_cs_n,
   input logic          ld_stb,
   input logic          wr_win,
   input logic          freeze,
   input logic          rfsh,
   input logic [VW-1:0] vis
);
   a_r2_drive_cond: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> (!cs_n && !oe_n && we_n));

   a_r2_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_oe |-> (rdata == 8'h00));

   a_r1_ram_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> ram_cs_n);

   a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> ram_cs_n);

   a_r3_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
      wr_win |=> !wr_win);

   a_r7_one_cycle_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stb |=> !ld_stb);

   a_r6_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !wr_win && !rfsh) |=> $stable(vis));
endmodule

bind rtc_window rtc_win_chk #(.VW(56)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
   .rdata(rdata), .rdata_oe(rdata_oe), .ram_cs_n(ram_cs_n), .ld_stb(ld_stb),
   .wr_win(wr_win), .freeze(freeze), .rfsh(rfsh), .vis(vis_q)
);

// File: tb/sim_rtc_window.sv
module sim_rtc_window;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 19;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic          rdata_oe, ram_cs_n;
   logic          tick_1s = 1'b0, hz512 = 1'b0;
   logic [55:0]   live_time = '0;
   logic          ld_stb;
   logic [55:0]   ld_time;
   logic          osc_stop;

   int errors = 0;
   int checks = 0;
   logic [7:0] exp [8];
   logic       last_ld;

   rtc_window u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
      .ram_cs_n(ram_cs_n), .tick_1s(tick_1s), .hz512(hz512),
      .live_time(live_time), .ld_stb(ld_stb), .ld_time(ld_time),
      .osc_stop(osc_stop)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] mask(int off);
      case (off)
         1: mask = 8'h7F; 2: mask = 8'h7F; 3: mask = 8'h3F; 4: mask = 8'h07;
         5: mask = 8'h3F; 6: mask = 8'h1F; 7: mask = 8'hFF;
         default: mask = 8'h00;
      endcase
   endfunction

   function automatic logic [AW-1:0] win(int off);
      win = {{(AW-3){1'b1}}, 3'(off)};
   endfunction

   function automatic logic [7:0] exp_read(int off);
      logic [7:0] b;
      b = exp[off];
      if (off == 1 && exp[4][6] && !exp[1][7]) b[0] = hz512;
      return b;
   endfunction

   function automatic logic [55:0] exp_ldt();
      logic [55:0] t;
      for (int k = 1; k < 8; k++) t[(k-1)*8 +: 8] = exp[k] & mask(k);
      return t;
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic wr(int off, logic [7:0] v);
      logic        el;
      logic [55:0] et;
      el = (off == 0) && exp[0][7] && !v[7];
      et = exp_ldt();
      @(negedge clk);
      addr = win(off); wdata = v; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
      @(posedge clk);
      #1;
      last_ld = ld_stb;
      chk("R7", 64'(ld_stb), 64'(el));
      if (el) chk("R7", 64'(ld_time), 64'(et));
      exp[off] = v;
      @(negedge clk);
      cs_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic rd(int off, string tag);
      @(negedge clk);
      addr = win(off); cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      #1;
      chk(tag, 64'(rdata), 64'(exp_read(off)));
      chk("R2", 64'(rdata_oe), 64'd1);
      chk("R1", 64'(ram_cs_n), 64'd1);
      cs_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic check_all(string tag);
      for (int k = 0; k < 8; k++) rd(k, tag);
   endtask

   task automatic tick(logic [55:0] lv);
      @(negedge clk);
      live_time = lv; tick_1s = 1'b1;
      @(posedge clk);
      if (!(exp[0][7] || exp[0][6]))
         for (int k = 1; k < 8; k++)
            exp[k] = (lv[(k-1)*8 +: 8] & mask(k)) | (exp[k] & ~mask(k));
      #1 tick_1s = 1'b0;
   endtask

   function automatic logic [55:0] live_pat(int i);
      logic [55:0] t;
      for (int k = 0; k < 7; k++) t[k*8 +: 8] = 8'((i * 37 + k * 11 + 5) & 255);
      return t;
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int k = 0; k < 8; k++) exp[k] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R12 reset state
      chk("R12", 64'(ld_stb), 64'd0);
      chk("R12", 64'(osc_stop), 64'd0);
      chk("R12", 64'(rdata_oe), 64'd0);
      check_all("R12");

      // R1 below-window access goes to RAM, window stays silent
      @(negedge clk);
      addr = win(7) - AW'(8); cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      #1;
      chk("R1", 64'(ram_cs_n), 64'd0);
      chk("R1", 64'(rdata_oe), 64'd0);
      chk("R1", 64'(rdata), 64'd0);
      addr = {1'b0, {(AW-1){1'b1}}};
      #1;
      chk("R1", 64'(ram_cs_n), 64'd0);
      chk("R1", 64'(rdata_oe), 64'd0);
      // R2 no drive without output enable or without select
      addr = win(0); oe_n = 1'b1;
      #1;
      chk("R2", 64'(rdata_oe), 64'd0);
      chk("R2", 64'(rdata), 64'd0);
      cs_n = 1'b1; oe_n = 1'b0;
      #1;
      chk("R2", 64'(rdata_oe), 64'd0);
      chk("R1", 64'(ram_cs_n), 64'd1);
      oe_n = 1'b1;

      // R5 full write/readback sweep with the write bit set
      wr(0, 8'h80);
      for (int off = 1; off < 8; off++)
         for (int v = 0; v < 256; v++) begin
            wr(off, 8'(v));
            rd(off, "R5");
         end
      for (int v = 0; v < 64; v++) begin
         wr(0, 8'h80 | 8'(v));
         rd(0, "R5");
      end
      wr(1, 8'h45); wr(2, 8'hB9); wr(3, 8'hD7); wr(4, 8'h82);
      wr(5, 8'h31); wr(6, 8'hE2); wr(7, 8'h99);
      // R6 frozen under the write bit
      for (int i = 0; i < 3; i++) tick(live_pat(i));
      check_all("R6");
      // R7 transfer on write-bit clear
      wr(0, 8'h15);
      chk("R7", 64'(last_ld), 64'd1);
      @(negedge clk);
      chk("R7", 64'(ld_stb), 64'd0);
      check_all("R7");

      // R4 tracking sweep, R5 unused bits retained
      for (int i = 0; i < 40; i++) begin
         tick(live_pat(i + 3));
         check_all("R4");
      end

      // R8 unfrozen write not transferred, then overwritten
      wr(2, 8'hAA);
      chk("R8", 64'(last_ld), 64'd0);
      rd(2, "R8");
      tick(live_pat(77));
      check_all("R8");

      // R3 single commit per access
      @(negedge clk);
      addr = win(2); wdata = 8'h11; cs_n = 1'b0; we_n = 1'b0;
      @(negedge clk) wdata = 8'h22;
      @(negedge clk) wdata = 8'h23;
      @(negedge clk) begin cs_n = 1'b1; we_n = 1'b1; end
      exp[2] = 8'h11;
      rd(2, "R3");
      @(negedge clk);
      addr = win(3); wdata = 8'h55; cs_n = 1'b0; we_n = 1'b1;
      @(negedge clk) begin we_n = 1'b0; wdata = 8'h33; end
      @(negedge clk) wdata = 8'h44;
      @(negedge clk) begin cs_n = 1'b1; we_n = 1'b1; end
      exp[3] = 8'h33;
      rd(3, "R3");

      // R6 read freeze, release, refresh only on a tick
      wr(0, 8'h40);
      for (int i = 0; i < 3; i++) tick(live_pat(100 + i));
      check_all("R6");
      wr(0, 8'h00);
      chk("R6", 64'(last_ld), 64'd0);
      check_all("R6");
      tick(live_pat(120));
      check_all("R6");

      // R9 both bits set, write bit cleared first
      wr(0, 8'hC0);
      wr(5, 8'h21);
      wr(1, 8'h12);
      wr(0, 8'h40);
      chk("R9", 64'(last_ld), 64'd1);
      tick(live_pat(130));
      check_all("R9");
      wr(0, 8'h00);
      chk("R9", 64'(last_ld), 64'd0);
      tick(live_pat(131));
      check_all("R9");

      // R10 oscillator stop follows seconds bit 7
      wr(1, 8'h80);
      chk("R10", 64'(osc_stop), 64'd1);
      wr(1, 8'h05);
      chk("R10", 64'(osc_stop), 64'd0);

      // R11 frequency test on seconds bit 0
      wr(4, 8'h43);
      wr(1, 8'h04);
      hz512 = 1'b1; rd(1, "R11");
      chk("R11", 64'(exp_read(1)), 64'h05);
      hz512 = 1'b0; rd(1, "R11");
      hz512 = 1'b1; rd(1, "R11");
      wr(1, 8'h84);
      rd(1, "R11");
      wr(1, 8'h04);
      wr(4, 8'h03);
      rd(1, "R11");
      hz512 = 1'b0;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule